// File: doc/BRIEF.md
# Segmented Unary/Binary Switch Decoder

This block turns a 10-bit sample code into the switch controls of a segmented current-steering converter. The upper six bits are handled as a unary segment: three of them select how many rows of an 8x8 grid of unit cells are full, the other three select how far the next row is filled. A row thermometer encoder and a column thermometer encoder drive shared row and column lines. Each cell then decides its own state from its row line, the line of the row below it and its column line. The lower four bits are carried through a dummy stage that matches the encoder delay. They then drive four binary-weighted cells.

Every control leaves the block from a flip-flop on one common clock edge, as a true/complement pair, so one switch of each differential pair is closed at any time. A user adds 16 units for every active unary cell and 2^k units for each active binary bit k, and gets back the code that was applied two clocks earlier. The reset input is asynchronous and active low. It is released through a two-flop synchronizer inside the block.

Top module: `seg_dac_decoder`

## Requirements
- R1: Code bits [9:7] form the row value R and bits [6:4] the column value C. The unary value is U = 8*R + C, and bits [3:0] form the binary value.
- R2: Each thermometer encoder drives line i high exactly when its 3-bit value is greater than i, so the active lines always fill from line 0 upward.
- R3: Unary cell n = 8*r + c (bit n of `cell_on`, 63 cells, n = 0..62) is on exactly when n < U. The cell is on when its row index is below R, or when its row equals R and its column index is below C.
- R4: Binary output bit k of `bin_on` equals code bit k (k = 0..3) and carries a weight of 2^k units.
- R5: Both the unary and the binary outputs show the code sampled two rising clock edges earlier.
- R6: Outside reset, `cell_on_n` is always the bitwise inverse of `cell_on`, and `bin_on_n` is always the bitwise inverse of `bin_on`.
- R7: While `rst_n` is low, every true output is 0 and every complement output is 1, with no clock edge needed.
- R8: Code 0 turns every cell off. Code 1023 turns on all 63 unary cells and all 4 binary cells.
- R9: 16 times the number of active unary cells plus the binary value equals the code applied two cycles before. This holds for every one of the 1024 codes, and for codes that change on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; all outputs update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| code | input | 10 | Sample code, sampled on every rising edge |
| cell_on | output | 63 | Unary cell enables, bit n = cell 8*r + c |
| cell_on_n | output | 63 | Complements of the unary cell enables |
| bin_on | output | 4 | Binary cell enables, bit k weighted 2^k |
| bin_on_n | output | 4 | Complements of the binary cell enables |

## Verification
The embedded properties check four things on every clock: that the row and column lines keep their thermometer shape, that the unary enables stay a contiguous fill from cell 0, that each true/complement pair stays inverse, and that the weighted sum matches the code from two edges back. The bench scenarios cover the rest. They show the exact row/column split for chosen codes, the asynchronous clearing during reset, the two endpoint codes, and an exhaustive sweep plus a pseudo-random stream with the code changing every cycle.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
  // Default segmentation of the converter code
  localparam int unsigned SEG_ROW_BITS = 3;
  localparam int unsigned SEG_COL_BITS = 3;
  localparam int unsigned SEG_BIN_BITS = 4;

  // Number of unary cells for a given segmentation (one short of the full grid)
  function automatic int unsigned seg_cell_count(input int unsigned row_bits,
                                                 input int unsigned col_bits);
    return (2 ** (row_bits + col_bits)) - 1;
  endfunction
endpackage

// File: rtl/seg_therm_enc.sv
module seg_therm_enc #(
  parameter int unsigned IN_W = 3,
  localparam int unsigned OUT_W = 2 ** IN_W
) (
  input  logic [IN_W-1:0]  value,
  output logic [OUT_W-1:0] lines
);
  // Line i is raised when the value exceeds i
  for (genvar i = 0; i < OUT_W; i++) begin : g_line
    assign lines[i] = (32'(value) > i);
  end
endmodule

// File: rtl/seg_cell_logic.sv
module seg_cell_logic (
  input  logic row_full,   // this row lies below the partial row
  input  logic row_reach,  // previous row full (or first row)
  input  logic col_on,     // column line for this cell
  output logic cell_en
);
  // A cell is on if its row is full, or if it sits on the partial row
  // and its column line is raised
  always_comb begin
    cell_en = row_full | (row_reach & col_on);
  end
endmodule

// File: rtl/seg_enc_stage.sv
module seg_enc_stage #(
  parameter int unsigned ROW_BITS = seg_dac_pkg::SEG_ROW_BITS,
  parameter int unsigned COL_BITS = seg_dac_pkg::SEG_COL_BITS,
  parameter int unsigned BIN_BITS = seg_dac_pkg::SEG_BIN_BITS,
  localparam int unsigned ROWS   = 2 ** ROW_BITS,
  localparam int unsigned COLS   = 2 ** COL_BITS,
  localparam int unsigned CODE_W = ROW_BITS + COL_BITS + BIN_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CODE_W-1:0]   code,
  output logic [ROWS-1:0]     row_lines_q,
  output logic [COLS-1:0]     col_lines_q,
  output logic [BIN_BITS-1:0] bin_q
);
  localparam int unsigned COL_LSB = BIN_BITS;
  localparam int unsigned ROW_LSB = BIN_BITS + COL_BITS;

  logic [ROW_BITS-1:0] row_val;
  logic [COL_BITS-1:0] col_val;
  logic [ROWS-1:0]     row_lines_d;
  logic [COLS-1:0]     col_lines_d;
  logic [BIN_BITS-1:0] bin_d;

  // Field split of the incoming code (R1)
  always_comb begin
    row_val = code[ROW_LSB +: ROW_BITS];
    col_val = code[COL_LSB +: COL_BITS];
  end

  seg_therm_enc #(.IN_W(ROW_BITS)) i_row_enc (
    .value (row_val),
    .lines (row_lines_d)
  );

  seg_therm_enc #(.IN_W(COL_BITS)) i_col_enc (
    .value (col_val),
    .lines (col_lines_d)
  );

  // Dummy stage on the binary path: same register depth as the encoders
  always_comb begin
    bin_d = code[BIN_BITS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_lines_q <= '0;
      col_lines_q <= '0;
      bin_q       <= '0;
    end else begin
      row_lines_q <= row_lines_d;
      col_lines_q <= col_lines_d;
      bin_q       <= bin_d;
    end
  end

  // Thermometer shape of the registered row and column lines (R2)
  assert_row_therm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (((ROWS+1)'(row_lines_q) + 1'b1) & (ROWS+1)'(row_lines_q)) == '0);
  assert_col_therm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (((COLS+1)'(col_lines_q) + 1'b1) & (COLS+1)'(col_lines_q)) == '0);
endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder #(
  parameter int unsigned ROW_BITS = seg_dac_pkg::SEG_ROW_BITS,
  parameter int unsigned COL_BITS = seg_dac_pkg::SEG_COL_BITS,
  parameter int unsigned BIN_BITS = seg_dac_pkg::SEG_BIN_BITS,
  localparam int unsigned ROWS   = 2 ** ROW_BITS,
  localparam int unsigned COLS   = 2 ** COL_BITS,
  localparam int unsigned CELLS  = seg_dac_pkg::seg_cell_count(ROW_BITS, COL_BITS),
  localparam int unsigned CODE_W = ROW_BITS + COL_BITS + BIN_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CODE_W-1:0]   code,
  output logic [CELLS-1:0]    cell_on,
  output logic [CELLS-1:0]    cell_on_n,
  output logic [BIN_BITS-1:0] bin_on,
  output logic [BIN_BITS-1:0] bin_on_n
);
  localparam int unsigned UNIT = 2 ** BIN_BITS;

  // Reset synchronizer: asserts at once, releases after two edges
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end

  always_comb begin
    rst_q_n = rst_sync[1];
  end

  // Stage 1: encoders and binary dummy delay
  logic [ROWS-1:0]     row_lines;
  logic [COLS-1:0]     col_lines;
  logic [BIN_BITS-1:0] bin_mid;

  seg_enc_stage #(
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS),
    .BIN_BITS (BIN_BITS)
  ) i_enc_stage (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .code        (code),
    .row_lines_q (row_lines),
    .col_lines_q (col_lines),
    .bin_q       (bin_mid)
  );

  // Per-cell local decode over the grid (R3)
  logic [CELLS-1:0] grid_en;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic reach;
    if (r == 0) begin : g_first
      assign reach = 1'b1;
    end else begin : g_next
      assign reach = row_lines[r-1];
    end
    for (genvar c = 0; c < COLS; c++) begin : g_col
      if (r * COLS + c < CELLS) begin : g_cell
        seg_cell_logic i_cell (
          .row_full  (row_lines[r]),
          .row_reach (reach),
          .col_on    (col_lines[c]),
          .cell_en   (grid_en[r*COLS+c])
        );
      end
    end
  end

  // Stage 2: switch-control registers, true and complement
  logic [CELLS-1:0]    cell_d, cell_dn;
  logic [BIN_BITS-1:0] bin_d, bin_dn;

  always_comb begin
    cell_d  = grid_en;
    cell_dn = ~grid_en;
    bin_d   = bin_mid;
    bin_dn  = ~bin_mid;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cell_on   <= '0;
      cell_on_n <= '1;
      bin_on    <= '0;
      bin_on_n  <= '1;
    end else begin
      cell_on   <= cell_d;
      cell_on_n <= cell_dn;
      bin_on    <= bin_d;
      bin_on_n  <= bin_dn;
    end
  end

  // Warm-up counter so latency checks only look at post-reset history
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)         warm <= 2'd0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  assert_cell_pair_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (cell_on ^ cell_on_n) == {CELLS{1'b1}});
  assert_bin_pair_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bin_on ^ bin_on_n) == {BIN_BITS{1'b1}});
  assert_unary_fill_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (((CELLS+1)'(cell_on) + 1'b1) & (CELLS+1)'(cell_on)) == '0);
  assert_sum_latency_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (warm == 2'd2) |->
      (($countones(cell_on) * UNIT + int'(bin_on)) == int'($past(code, 2))));
  assert_full_scale_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (warm == 2'd2 && $past(code, 2) == {CODE_W{1'b1}}) |->
      (cell_on == {CELLS{1'b1}} && bin_on == {BIN_BITS{1'b1}}));
endmodule

// File: tb/test_seg_dac_decoder.sv
module test_seg_dac_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  code;
  logic [62:0] cell_on, cell_on_n;
  logic [3:0]  bin_on, bin_on_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  seg_dac_decoder i_seg_dac_decoder (
    .clk       (clk),
    .rst_n     (rst_n),
    .code      (code),
    .cell_on   (cell_on),
    .cell_on_n (cell_on_n),
    .bin_on    (bin_on),
    .bin_on_n  (bin_on_n)
  );

  function automatic logic [62:0] exp_cells(input logic [9:0] c);
    logic [62:0] v = '0;
    for (int i = 0; i < 63; i++) if (i < int'(c[9:4])) v[i] = 1'b1;
    return v;
  endfunction

  // Compare every output against the code applied two edges earlier
  task automatic check_code(input logic [9:0] c, input string req);
    logic [62:0] ec;
    int sum;
    ec  = exp_cells(c);
    sum = $countones(cell_on) * 16 + int'(bin_on);
    checks++;
    if (cell_on !== ec || cell_on_n !== ~ec || bin_on !== c[3:0] ||
        bin_on_n !== ~c[3:0] || sum != int'(c)) begin
      errors++;
      $display("FAIL %s code=%0d cells=%h/%h bin=%b/%b sum=%0d expected cells=%h bin=%b sum=%0d",
               req, c, cell_on, cell_on_n, bin_on, bin_on_n, sum, ec, c[3:0], c);
    end
  endtask

  // Hold one code until it has passed both register stages
  task automatic apply_hold(input logic [9:0] c, input string req);
    @(negedge clk) code = c;
    @(negedge clk);
    @(negedge clk);
    check_code(c, req);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    #1;
    checks++;
    if (cell_on !== '0 || cell_on_n !== '1 || bin_on !== '0 || bin_on_n !== '1) begin
      errors++;
      $display("FAIL R7 reset outputs cells=%h/%h bin=%b/%b expected 0/all-ones",
               cell_on, cell_on_n, bin_on, bin_on_n);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic test_reset_state();
    code = 10'h3FF;
    rst_n = 1'b0;
    #1;
    repeat (2) @(negedge clk);
    checks++;
    if (cell_on !== '0 || cell_on_n !== '1 || bin_on !== '0 || bin_on_n !== '1) begin
      errors++;
      $display("FAIL R7 initial reset cells=%h/%h bin=%b/%b expected all off",
               cell_on, cell_on_n, bin_on, bin_on_n);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic test_split();
    // R1 R3: R=2, C=3 fills cells 0..18
    apply_hold(10'b010_011_0000, "R1 R3 partial row");
    // R2: C=0 gives whole rows only (R=3 -> 24 cells)
    apply_hold(10'b011_000_0000, "R2 full rows");
    // R2: R=0, C=7 fills first row except last column
    apply_hold(10'b000_111_0000, "R2 column fill");
    // R4: binary bits alone
    apply_hold(10'b000_000_1010, "R4 binary only");
    apply_hold(10'b111_110_0101, "R3 R4 last row partial");
  endtask

  task automatic test_endpoints();
    apply_hold(10'd0, "R8 code zero");
    apply_hold(10'd1023, "R8 full scale");
    apply_hold(10'd16, "R3 single unary cell");
    apply_hold(10'd15, "R4 binary full");
  endtask

  task automatic test_latency();
    // R5: one cycle after change, the old code must still be shown
    @(negedge clk) code = 10'd0;
    repeat (2) @(negedge clk);
    code = 10'd1023;
    @(negedge clk);
    check_code(10'd0, "R5 one cycle later still old");
    @(negedge clk);
    check_code(10'd1023, "R5 two cycles later new");
  endtask

  task automatic test_sweep();
    logic [9:0] hist [2];
    for (int i = 0; i < 1026; i++) begin
      @(negedge clk);
      if (i >= 2) check_code(hist[1], "R9 sweep");
      hist[1] = hist[0];
      hist[0] = 10'(i);
      code = 10'(i);
    end
  endtask

  task automatic test_random();
    logic [15:0] lfsr = 16'hACE1;
    logic [9:0]  hist [2];
    for (int i = 0; i < 302; i++) begin
      @(negedge clk);
      if (i >= 2) check_code(hist[1], "R9 random stream");
      hist[1] = hist[0];
      hist[0] = lfsr[9:0];
      code = lfsr[9:0];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
  endtask

  task automatic test_mid_reset();
    apply_hold(10'd777, "R9 before reset");
    do_reset();
    apply_hold(10'd555, "R7 after reset release");
  endtask

  initial begin
    test_reset_state();
    test_split();
    test_endpoints();
    test_latency();
    test_sweep();
    test_random();
    test_mid_reset();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule